// File: doc/BRIEF.md
# Sign-Extension-Gated Adder/Subtractor

This block adds or subtracts two 16-bit two's-complement operands and registers the 16-bit result together with a carry-out. The datapath is cut into a lower byte and an upper byte. The lower byte is always computed by its own 8-bit adder. The upper byte has its own adder, but that adder is used only when at least one operand carries real information above bit 7.

A detector examines both operands on every cycle. If each operand's upper byte is only a copy of its bit 7, the upper adder is skipped. Its inputs are then frozen at the last values it was given, which keeps its nets from toggling. The upper result byte and the carry-out are instead produced by a small sign-fill circuit. That circuit works from the two sign bits and the carry leaving the lower byte, so the registered result is always the exact sum or difference.

The block is meant as the accumulate adder behind a multiplier that works on mostly small values. It is used like any registered adder: present the operands and the operation, and read the result one clock later.

Top module: `spst_addsub`

## Requirements
- R1: While rst_n is low, sum and cout are 0.
- R2: With sub = 0, one clock edge after the inputs are presented, {cout, sum} equals the 17-bit unsigned sum a + b.
- R3: With sub = 1, one clock edge later {cout, sum} equals the 17-bit value a + ~b + 1. So cout = 1 means no borrow, and sum is a − b modulo 2^16.
- R4: A carry out of bit 7 of the lower byte always reaches bit 8 of the result, both when the upper byte is computed and when it is sign-filled.
- R5: The upper adder is skipped exactly when bits 15:8 of a all equal a[7] and bits 15:8 of b all equal b[7].
- R6: When the upper adder is skipped, sum[15:8] are all equal. The 16-bit result and cout still match R2/R3, including when the operand signs differ and the lower byte overflows.
- R7: While the upper adder is skipped, its inputs hold the values of the last cycle that was not skipped. A later cycle that is not skipped gives a correct result.
- R8: The result has a latency of exactly one clock. Each edge registers the operation that was present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; result registered on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| sub | input | 1 | 0 = add, 1 = subtract b from a |
| sum | output | 16 | Registered result |
| cout | output | 1 | Registered carry-out (no-borrow flag when subtracting) |

## Verification
The bench concentrates on operand pairs that fall into the skipped case but whose lower bytes carry or overflow. Examples are 0xFFFF + 0x0001 and 0x0050 + 0x0040. A sign-fill circuit that copied bit 7 of the lower sum, or that ignored the lower carry, would return a wrong upper byte or a wrong carry-out for them. Subtractions are checked in both the skipped and the computed case. This catches a detector that looks at the inverted operand in the wrong way, and a forgotten forced carry-in, which would give results off by one. Long runs of skipped operations followed by one wide operation test that the frozen upper inputs are released in time and do not leak stale values into the result.

// File: rtl/spst_pkg.sv
package spst_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

endpackage

// File: rtl/spst_seg_adder.sv
module spst_seg_adder #(
    parameter int SEG_W = 8
) (
    input  logic [SEG_W-1:0] x,
    input  logic [SEG_W-1:0] y,
    input  logic             cin,
    output logic [SEG_W-1:0] s,
    output logic             co
);
    localparam int EXT_W = SEG_W + 1;

    logic [EXT_W-1:0] total;

    always_comb begin
        total = {1'b0, x} + {1'b0, y} + {{SEG_W{1'b0}}, cin};
        s     = total[SEG_W-1:0];
        co    = total[SEG_W];
    end
endmodule

// File: rtl/spst_ext_detect.sv
module spst_ext_detect #(
    parameter int DATA_W = 16,
    parameter int LOW_W  = 8
) (
    input  logic [DATA_W-1:0] opnd,
    output logic              quiet
);
    localparam int HIGH_W = DATA_W - LOW_W;

    logic [HIGH_W-1:0] match;

    for (genvar i = 0; i < HIGH_W; i++) begin : g_cmp
        assign match[i] = (opnd[LOW_W + i] == opnd[LOW_W-1]);
    end

    assign quiet = &match;
endmodule

// File: rtl/spst_sign_fill.sv
module spst_sign_fill #(
    parameter int HIGH_W = 8
) (
    input  logic              sign_x,
    input  logic              sign_y,
    input  logic              c_low,
    output logic [HIGH_W-1:0] fill,
    output logic              co
);
    logic fill_bit;

    always_comb begin
        // Upper bytes are 0x00 or 0xFF: their sum plus c_low is a pure
        // replication of one bit, with a carry-out derived from the same terms.
        fill_bit = (sign_x & sign_y) | ((sign_x ^ sign_y) & ~c_low);
        co       = (sign_x & sign_y) | ((sign_x ^ sign_y) &  c_low);
        fill     = {HIGH_W{fill_bit}};
    end
endmodule

// File: rtl/spst_addsub.sv
module spst_addsub #(
    parameter int DATA_W = 16,
    parameter int LOW_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              cout
);
    import spst_pkg::*;

    localparam int HIGH_W = DATA_W - LOW_W;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              co;
        logic [HIGH_W-1:0] hold_x;
        logic [HIGH_W-1:0] hold_y;
        logic              live;
    } state_t;

    state_t st_d, st_q;

    op_e               op;
    logic [DATA_W-1:0] b_eff;
    logic              cin;
    logic              quiet_a, quiet_b, skip;
    logic [LOW_W-1:0]  lo_sum;
    logic              c_lo;
    logic [HIGH_W-1:0] up_x, up_y, up_sum, fill;
    logic              c_up, c_fill;

    assign op    = op_e'(sub);
    assign b_eff = (op == OP_SUB) ? ~b : b;
    assign cin   = (op == OP_SUB);

    spst_ext_detect #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_det_a (
        .opnd (a),
        .quiet(quiet_a)
    );

    spst_ext_detect #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_det_b (
        .opnd (b),
        .quiet(quiet_b)
    );

    assign skip = quiet_a & quiet_b;

    spst_seg_adder #(.SEG_W(LOW_W)) u_lo (
        .x  (a[LOW_W-1:0]),
        .y  (b_eff[LOW_W-1:0]),
        .cin(cin),
        .s  (lo_sum),
        .co (c_lo)
    );

    // Frozen operands feed the upper adder while it is not needed
    assign up_x = skip ? st_q.hold_x : a[DATA_W-1:LOW_W];
    assign up_y = skip ? st_q.hold_y : b_eff[DATA_W-1:LOW_W];

    spst_seg_adder #(.SEG_W(HIGH_W)) u_hi (
        .x  (up_x),
        .y  (up_y),
        .cin(c_lo),
        .s  (up_sum),
        .co (c_up)
    );

    spst_sign_fill #(.HIGH_W(HIGH_W)) u_fill (
        .sign_x(a[LOW_W-1]),
        .sign_y(b_eff[LOW_W-1]),
        .c_low (c_lo),
        .fill  (fill),
        .co    (c_fill)
    );

    always_comb begin
        st_d      = st_q;
        st_d.live = 1'b1;
        st_d.res  = {(skip ? fill : up_sum), lo_sum};
        st_d.co   = skip ? c_fill : c_up;
        if (!skip) begin
            st_d.hold_x = a[DATA_W-1:LOW_W];
            st_d.hold_y = b_eff[DATA_W-1:LOW_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum  = st_q.res;
    assign cout = st_q.co;

    // Independent full-width reference for the assertions
    logic [DATA_W:0] ref_full;
    assign ref_full = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (sum == '0 && cout == 1'b0)); // R1

    AST_EXACT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({cout, sum} == $past(ref_full))); // R2

    AST_FILL_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        skip |=> (sum[DATA_W-1:LOW_W] == '0 || sum[DATA_W-1:LOW_W] == '1)); // R6

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && skip) |=> (st_q.hold_x == $past(st_q.hold_x)
                                 && st_q.hold_y == $past(st_q.hold_y))); // R7

    AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && skip) |=> (!skip || ($stable(up_x) && $stable(up_y)))); // R7

    AST_SKIP_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> (a[DATA_W-1:LOW_W] == {HIGH_W{a[LOW_W-1]}}
                  && b_eff[DATA_W-1:LOW_W] == {HIGH_W{b_eff[LOW_W-1]}})); // R5
endmodule

// File: tb/sim_spst_addsub.sv
module sim_spst_addsub;

    logic        clk;
    logic        rst_n;
    logic [15:0] a, b;
    logic        sub;
    logic [15:0] sum;
    logic        cout;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    spst_addsub u0 (
        .clk  (clk),
        .rst_n(rst_n),
        .a    (a),
        .b    (b),
        .sub  (sub),
        .sum  (sum),
        .cout (cout)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // {sub, a, b}
    localparam logic [32:0] VEC [12] = '{
        {1'b0, 16'h0003, 16'h0004},
        {1'b0, 16'h7FFF, 16'h0001},
        {1'b0, 16'hFFFF, 16'h0001},
        {1'b0, 16'h0050, 16'h0040},
        {1'b0, 16'hFF80, 16'hFF80},
        {1'b1, 16'h1234, 16'h0234},
        {1'b1, 16'h0005, 16'h0007},
        {1'b1, 16'h0007, 16'h0005},
        {1'b1, 16'h8000, 16'h0001},
        {1'b0, 16'hABCD, 16'h5433},
        {1'b0, 16'h007F, 16'h0001},
        {1'b1, 16'hFF80, 16'h007F}
    };

    function automatic logic [16:0] expect_of(logic s, logic [15:0] x, logic [15:0] y);
        if (s) return {1'b0, x} + {1'b0, ~y} + 17'd1;
        return {1'b0, x} + {1'b0, y};
    endfunction

    task automatic check(string req, logic [16:0] got, logic [16:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive at negedge, sample 1 ns after the capturing posedge
    task automatic run_op(string req, logic s, logic [15:0] x, logic [15:0] y);
        @(negedge clk);
        a = x; b = y; sub = s;
        @(posedge clk);
        #1;
        check(req, {cout, sum}, expect_of(s, x, y));
    endtask

    function automatic logic [15:0] sext(logic [7:0] v);
        return {{8{v[7]}}, v};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        a = 16'h1234; b = 16'h4321; sub = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {cout, sum}, 17'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4 R6: table walk
        for (int i = 0; i < 12; i++) begin
            run_op("R2/R3/R4/R6 table", VEC[i][32], VEC[i][31:16], VEC[i][15:0]);
        end

        // R6: skipped, mixed signs, lower carry -> upper 0x00, cout 1
        run_op("R6 mixed-sign carry", 1'b0, 16'hFFF0, 16'h0020);
        // R4: carry across bit 8 with upper adder active
        run_op("R4 carry into upper", 1'b0, 16'h01FF, 16'h0001);

        // R8: back-to-back operations each land one edge later
        @(negedge clk);
        a = 16'h0100; b = 16'h0200; sub = 1'b0;
        @(posedge clk);
        @(negedge clk);
        a = 16'h0010; b = 16'h0001; sub = 1'b1;
        check("R8 latency first", {cout, sum}, 17'h00300);
        @(posedge clk);
        #1;
        check("R8 latency second", {cout, sum}, 17'h1000F);

        // R7: long skipped run, then a wide operation
        run_op("R7 prime", 1'b0, 16'h4000, 16'h2000);
        for (int i = 0; i < 40; i++) begin
            run_op("R7 skipped run", i[0], sext(8'(i * 37)), sext(8'(255 - i * 11)));
        end
        run_op("R7 wide after run", 1'b1, 16'h3A00, 16'h1C05);

        // R5 R6: random sign-extended operands
        for (int i = 0; i < 300; i++) begin
            run_op("R5/R6 random narrow", 1'($urandom), sext(8'($urandom)), sext(8'($urandom)));
        end
        // R2 R3: random full-width operands
        for (int i = 0; i < 300; i++) begin
            run_op("R2/R3 random wide", 1'($urandom), 16'($urandom), 16'($urandom));
        end

        // R1: reset again after activity
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset after use", {cout, sum}, 17'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule